// File: doc/BRIEF.md
# Power Island On/Off Sequencer

This block brings a single switchable power island up or down in hardware, one step per clock, in answer to a one-cycle request. It owns a five-bit control word for the island's power cell: an active-low reset release, an isolation clamp, a primary and a secondary power switch, and a clock gate. It also drives an SRAM power-down vector and a bus-protection request. While it runs it watches two power-good acknowledges, the SRAM power-down acknowledges and the bus-protection acknowledge.

Power-up closes the primary switch and then the secondary switch. It then waits until both power acknowledges are high. After that it ungates the clock, drops isolation, releases reset, powers the SRAM up and lifts bus protection. Power-down runs the same steps in mirror order and finishes once both power acknowledges are low. Every wait has a timeout measured in clock cycles. A power-up that times out puts the island back into its safe off state. Any timeout raises an error pulse.

An island with nothing to protect on the bus is built with bus protection disabled. The sequencer then skips that handshake in both directions. A supply-enable output follows the island's requested power state, for use by a voltage regulator.

Top module: `pwr_island_seq`

## Requirements
- R1: After reset the control word `pwr_ctl` is 5'b10010. That is bit0 reset-release=0, bit1 isolation=1, bit2 primary switch=0, bit3 secondary switch=0, bit4 clock-disable=1. Also after reset: `mem_pd` is all ones, `bp_req` equals USE_BP, and `supply_en`, `busy`, `done` and `err` are all 0.
- R2: When a power-up is accepted, `supply_en` and `busy` rise at that edge. The primary switch (bit2) is set on the next cycle and the secondary switch (bit3) on the cycle after.
- R3: The power-up sequence moves past its acknowledge wait only when `pwr_ack_a` and `pwr_ack_b` are both 1. With only one of them high it keeps waiting, and every later control bit holds its value.
- R4: After the acknowledge, clock-disable (bit4) clears first, then isolation (bit1) clears, then reset-release (bit0) sets. Each of these happens on its own consecutive cycle.
- R5: After reset release, `mem_pd` goes to all zeros and the sequencer waits for all of `mem_pd_ack` to be 0. Then `bp_req` drops and it waits for `bp_ack` to be 0. Then it pulses `done`.
- R6: Power-down first raises `bp_req` and waits for `bp_ack` to be 1. Next it sets `mem_pd` to all ones and waits for all of `mem_pd_ack` to be 1. Then, one cycle each and in this order, it sets isolation, clears reset-release, sets clock-disable, clears the primary switch and clears the secondary switch.
- R7: Power-down completes only when both power acknowledges are 0. At that edge `done` pulses and `supply_en` falls.
- R8: A wait that has not been met after TIMEOUT_CYC cycles in its state raises `err` for exactly one cycle, and the sequencer goes back to idle. `done` and `err` are never high together.
- R9: A power-up timeout puts every output back to its reset value (R1) at the same edge that raises `err`. A power-down timeout leaves the outputs as they are.
- R10: With USE_BP=0, `bp_req` stays 0, `bp_ack` is ignored, and both sequences leave out the bus-protection steps.
- R11: `busy` is high from the cycle after acceptance until the cycle in which `done` or `err` pulses, and it is low in that cycle. A request that arrives while `busy` is high is ignored.
- R12: When `on_req` and `off_req` arrive in the same idle cycle, the power-up wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| on_req | input | 1 | One-cycle power-up request |
| off_req | input | 1 | One-cycle power-down request |
| pwr_ack_a | input | 1 | First power-good acknowledge |
| pwr_ack_b | input | 1 | Second power-good acknowledge |
| mem_pd_ack | input | MEM_W | SRAM power-down acknowledges |
| bp_ack | input | 1 | Bus-protection acknowledge |
| pwr_ctl | output | 5 | Island control word (bit layout in R1) |
| mem_pd | output | MEM_W | SRAM power-down controls |
| bp_req | output | 1 | Bus-protection request |
| supply_en | output | 1 | Supply enable for the island |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle sequence-complete pulse |
| err | output | 1 | One-cycle timeout pulse |

## Verification
The bench builds two copies of the block. Both use MEM_W=4 and TIMEOUT_CYC=16; one has USE_BP=1 and the other USE_BP=0. The short timeout lets every wait be starved until it expires within a few dozen cycles, so power-up teardown and power-down failure each take one short test. The second copy runs the same stimulus with its bus-protection acknowledge held high, which shows the skipped handshake as a sequence that is two steps shorter.

// File: rtl/pwr_island_pkg.sv
`timescale 1ns/1ps
package pwr_island_pkg;

  // Control word bit positions; the power cell decodes these.
  localparam int CTL_W      = 5;
  localparam int CB_RST_N   = 0;
  localparam int CB_ISO     = 1;
  localparam int CB_SW_PRI  = 2;
  localparam int CB_SW_SEC  = 3;
  localparam int CB_CLK_OFF = 4;

  // Safe off value: clock gated, isolated, switches open, reset held.
  localparam logic [CTL_W-1:0] CTL_DOWN = 5'b10010;

  typedef enum logic [1:0] {
    LVL_OFF   = 2'd0,
    LVL_ON    = 2'd1,
    LVL_MIXED = 2'd2
  } ack_lvl_e;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_UP_SW_PRI,
    ST_UP_SW_SEC,
    ST_UP_ACK,
    ST_UP_CLK,
    ST_UP_ISO,
    ST_UP_RST,
    ST_UP_MEM_REQ,
    ST_UP_MEM_WAIT,
    ST_UP_BP_REQ,
    ST_UP_BP_WAIT,
    ST_DN_BP_REQ,
    ST_DN_BP_WAIT,
    ST_DN_MEM_REQ,
    ST_DN_MEM_WAIT,
    ST_DN_ISO,
    ST_DN_RST,
    ST_DN_CLK,
    ST_DN_SW_PRI,
    ST_DN_SW_SEC,
    ST_DN_ACK
  } seq_state_e;

  // Two-status rule: agreement gives a level, disagreement means transition.
  function automatic ack_lvl_e f_ack_lvl(input logic a, input logic b);
    if (a && b)   return LVL_ON;
    if (!a && !b) return LVL_OFF;
    return LVL_MIXED;
  endfunction

  function automatic logic f_is_wait(input seq_state_e s);
    return s inside {ST_UP_ACK, ST_UP_MEM_WAIT, ST_UP_BP_WAIT,
                     ST_DN_BP_WAIT, ST_DN_MEM_WAIT, ST_DN_ACK};
  endfunction

  function automatic logic f_is_up(input seq_state_e s);
    return s inside {ST_UP_SW_PRI, ST_UP_SW_SEC, ST_UP_ACK, ST_UP_CLK,
                     ST_UP_ISO, ST_UP_RST, ST_UP_MEM_REQ, ST_UP_MEM_WAIT,
                     ST_UP_BP_REQ, ST_UP_BP_WAIT};
  endfunction

endpackage

// File: rtl/pwr_ack_eval.sv
`timescale 1ns/1ps
module pwr_ack_eval
  import pwr_island_pkg::*;
#(
  parameter int MEM_W = 4
) (
  input  logic             ack_a,
  input  logic             ack_b,
  input  logic [MEM_W-1:0] mem_ack,
  output ack_lvl_e         lvl,
  output logic             mem_clr,
  output logic             mem_set
);

  assign lvl = f_ack_lvl(ack_a, ack_b);

  always_comb begin
    mem_clr = 1'b1;
    mem_set = 1'b1;
    for (int i = 0; i < MEM_W; i++) begin
      mem_clr = mem_clr & ~mem_ack[i];
      mem_set = mem_set &  mem_ack[i];
    end
  end

endmodule

// File: rtl/pwr_wait_timer.sv
`timescale 1ns/1ps
module pwr_wait_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);

  localparam int            CW   = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run)         cnt <= '0;
    else if (cnt != LAST)  cnt <= cnt + CW'(1);
  end

  assign expired = run && (cnt == LAST);

endmodule

// File: rtl/pwr_step_fsm.sv
`timescale 1ns/1ps
module pwr_step_fsm
  import pwr_island_pkg::*;
#(
  parameter int MEM_W  = 4,
  parameter bit USE_BP = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             on_req,
  input  logic             off_req,
  input  ack_lvl_e         lvl,
  input  logic             mem_clr,
  input  logic             mem_set,
  input  logic             bp_ack,
  input  logic             expired,
  output logic [CTL_W-1:0] ctl,
  output logic [MEM_W-1:0] mem_pd,
  output logic             bp_req,
  output logic             supply_en,
  output logic             done,
  output logic             err,
  output logic             busy,
  output logic             wait_st,
  output logic             accept_ev
);

  localparam logic [MEM_W-1:0] MEM_ALL = {MEM_W{1'b1}};

  seq_state_e st;
  logic       wait_ok;

  always_comb begin
    case (st)
      ST_UP_ACK:      wait_ok = (lvl == LVL_ON);
      ST_UP_MEM_WAIT: wait_ok = mem_clr;
      ST_UP_BP_WAIT:  wait_ok = ~bp_ack;
      ST_DN_BP_WAIT:  wait_ok = bp_ack;
      ST_DN_MEM_WAIT: wait_ok = mem_set;
      ST_DN_ACK:      wait_ok = (lvl == LVL_OFF);
      default:        wait_ok = 1'b0;
    endcase
  end

  assign busy      = (st != ST_IDLE);
  assign wait_st   = f_is_wait(st);
  assign accept_ev = (st == ST_IDLE) && (on_req || off_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      ctl       <= CTL_DOWN;
      mem_pd    <= MEM_ALL;
      bp_req    <= USE_BP;
      supply_en <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (wait_st && !wait_ok && expired) begin
        st  <= ST_IDLE;
        err <= 1'b1;
        if (f_is_up(st)) begin
          ctl       <= CTL_DOWN;
          mem_pd    <= MEM_ALL;
          bp_req    <= USE_BP;
          supply_en <= 1'b0;
        end
      end else begin
        case (st)
          ST_IDLE: begin
            if (on_req) begin
              st        <= ST_UP_SW_PRI;
              supply_en <= 1'b1;
            end else if (off_req) begin
              st <= USE_BP ? ST_DN_BP_REQ : ST_DN_MEM_REQ;
            end
          end
          ST_UP_SW_PRI: begin ctl[CB_SW_PRI]  <= 1'b1; st <= ST_UP_SW_SEC; end
          ST_UP_SW_SEC: begin ctl[CB_SW_SEC]  <= 1'b1; st <= ST_UP_ACK;    end
          ST_UP_ACK:    if (wait_ok) st <= ST_UP_CLK;
          ST_UP_CLK:    begin ctl[CB_CLK_OFF] <= 1'b0; st <= ST_UP_ISO;     end
          ST_UP_ISO:    begin ctl[CB_ISO]     <= 1'b0; st <= ST_UP_RST;     end
          ST_UP_RST:    begin ctl[CB_RST_N]   <= 1'b1; st <= ST_UP_MEM_REQ; end
          ST_UP_MEM_REQ: begin mem_pd <= '0; st <= ST_UP_MEM_WAIT; end
          ST_UP_MEM_WAIT: begin
            if (wait_ok) begin
              if (USE_BP) st <= ST_UP_BP_REQ;
              else begin
                st   <= ST_IDLE;
                done <= 1'b1;
              end
            end
          end
          ST_UP_BP_REQ: begin bp_req <= 1'b0; st <= ST_UP_BP_WAIT; end
          ST_UP_BP_WAIT: begin
            if (wait_ok) begin
              st   <= ST_IDLE;
              done <= 1'b1;
            end
          end
          ST_DN_BP_REQ:   begin bp_req <= 1'b1; st <= ST_DN_BP_WAIT; end
          ST_DN_BP_WAIT:  if (wait_ok) st <= ST_DN_MEM_REQ;
          ST_DN_MEM_REQ:  begin mem_pd <= MEM_ALL; st <= ST_DN_MEM_WAIT; end
          ST_DN_MEM_WAIT: if (wait_ok) st <= ST_DN_ISO;
          ST_DN_ISO:    begin ctl[CB_ISO]     <= 1'b1; st <= ST_DN_RST;    end
          ST_DN_RST:    begin ctl[CB_RST_N]   <= 1'b0; st <= ST_DN_CLK;    end
          ST_DN_CLK:    begin ctl[CB_CLK_OFF] <= 1'b1; st <= ST_DN_SW_PRI; end
          ST_DN_SW_PRI: begin ctl[CB_SW_PRI]  <= 1'b0; st <= ST_DN_SW_SEC; end
          ST_DN_SW_SEC: begin ctl[CB_SW_SEC]  <= 1'b0; st <= ST_DN_ACK;    end
          ST_DN_ACK: begin
            if (wait_ok) begin
              st        <= ST_IDLE;
              done      <= 1'b1;
              supply_en <= 1'b0;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/pwr_island_seq.sv
`timescale 1ns/1ps
module pwr_island_seq
  import pwr_island_pkg::*;
#(
  parameter int MEM_W       = 4,
  parameter int TIMEOUT_CYC = 1024,
  parameter bit USE_BP      = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             on_req,
  input  logic             off_req,
  input  logic             pwr_ack_a,
  input  logic             pwr_ack_b,
  input  logic [MEM_W-1:0] mem_pd_ack,
  input  logic             bp_ack,
  output logic [CTL_W-1:0] pwr_ctl,
  output logic [MEM_W-1:0] mem_pd,
  output logic             bp_req,
  output logic             supply_en,
  output logic             busy,
  output logic             done,
  output logic             err
);

  // Named internal events, visible to the bound checker.
  ack_lvl_e ack_lvl;
  logic     mem_clr;
  logic     mem_set;
  logic     wait_st;
  logic     expired;
  logic     ev_accept;

  pwr_ack_eval #(.MEM_W(MEM_W)) u_eval (
    .ack_a   (pwr_ack_a),
    .ack_b   (pwr_ack_b),
    .mem_ack (mem_pd_ack),
    .lvl     (ack_lvl),
    .mem_clr (mem_clr),
    .mem_set (mem_set)
  );

  pwr_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (wait_st),
    .expired (expired)
  );

  pwr_step_fsm #(.MEM_W(MEM_W), .USE_BP(USE_BP)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .on_req    (on_req),
    .off_req   (off_req),
    .lvl       (ack_lvl),
    .mem_clr   (mem_clr),
    .mem_set   (mem_set),
    .bp_ack    (bp_ack),
    .expired   (expired),
    .ctl       (pwr_ctl),
    .mem_pd    (mem_pd),
    .bp_req    (bp_req),
    .supply_en (supply_en),
    .done      (done),
    .err       (err),
    .busy      (busy),
    .wait_st   (wait_st),
    .accept_ev (ev_accept)
  );

endmodule

// File: rtl/pwr_island_seq_chk.sv
`timescale 1ns/1ps
module pwr_island_seq_chk
  import pwr_island_pkg::*;
#(
  parameter int MEM_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             on_req,
  input logic             off_req,
  input logic             ack_a,
  input logic             ack_b,
  input logic [CTL_W-1:0] ctl,
  input logic [MEM_W-1:0] mem_pd,
  input logic             bp_req,
  input logic             supply_en,
  input logic             busy,
  input logic             done,
  input logic             err
);

  assert_sec_after_pri_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl[CB_SW_SEC]) |-> ctl[CB_SW_PRI] && $past(ctl[CB_SW_PRI]));

  assert_ungate_needs_both_acks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl[CB_CLK_OFF]) |-> $past(ack_a && ack_b, 2));

  assert_iso_after_ungate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl[CB_ISO]) |-> !ctl[CB_CLK_OFF] && $past(!ctl[CB_CLK_OFF]));

  assert_rst_after_iso_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl[CB_RST_N]) |-> !ctl[CB_ISO] && $past(!ctl[CB_ISO]));

  assert_mem_up_after_rst_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_pd[0]) |-> ctl[CB_RST_N]);

  assert_bp_drop_after_mem_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bp_req) |-> (mem_pd == '0));

  assert_iso_after_mem_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl[CB_ISO]) |-> (&mem_pd));

  assert_sec_opens_after_pri_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl[CB_SW_SEC]) |-> !ctl[CB_SW_PRI]);

  assert_supply_drop_ends_seq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(supply_en) |-> (done || err));

  assert_err_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  assert_done_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  assert_idle_at_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> !busy);

  assert_busy_from_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(on_req || off_req));

endmodule

bind pwr_island_seq pwr_island_seq_chk #(.MEM_W(MEM_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .on_req    (on_req),
  .off_req   (off_req),
  .ack_a     (pwr_ack_a),
  .ack_b     (pwr_ack_b),
  .ctl       (pwr_ctl),
  .mem_pd    (mem_pd),
  .bp_req    (bp_req),
  .supply_en (supply_en),
  .busy      (busy),
  .done      (done),
  .err       (err)
);

// File: tb/test_pwr_island_seq.sv
`timescale 1ns/1ps
module test_pwr_island_seq;

  localparam int MEM_W = 4;
  localparam int TO    = 16;
  localparam int NTR   = 40;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic on_req = 1'b0;
  logic off_req = 1'b0;

  // main copy (bus protection present)
  logic             ack_a = 1'b0, ack_b = 1'b0, bp_ack = 1'b1;
  logic [MEM_W-1:0] mem_ack = '1;
  logic [4:0]       ctl;
  logic [MEM_W-1:0] mem_pd;
  logic             bp_req, sup, busy, done, err;

  // second copy (no bus protection)
  logic             ack2_a = 1'b0, ack2_b = 1'b0;
  logic             bp2_ack = 1'b1;
  logic [MEM_W-1:0] mem2_ack = '1;
  logic [4:0]       ctl2;
  logic [MEM_W-1:0] mem2_pd;
  logic             bp2_req, sup2, busy2, done2, err2;

  // responder overrides for the main copy
  logic hold_a = 1'b0, hv_a = 1'b0;
  logic hold_b = 1'b0, hv_b = 1'b0;
  logic hold_bp = 1'b0, hv_bp = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  pwr_island_seq #(.MEM_W(MEM_W), .TIMEOUT_CYC(TO), .USE_BP(1'b1)) i_pwr_island_seq (
    .clk(clk), .rst_n(rst_n), .on_req(on_req), .off_req(off_req),
    .pwr_ack_a(ack_a), .pwr_ack_b(ack_b), .mem_pd_ack(mem_ack), .bp_ack(bp_ack),
    .pwr_ctl(ctl), .mem_pd(mem_pd), .bp_req(bp_req), .supply_en(sup),
    .busy(busy), .done(done), .err(err)
  );

  pwr_island_seq #(.MEM_W(MEM_W), .TIMEOUT_CYC(TO), .USE_BP(1'b0)) i_pwr_island_seq_nobp (
    .clk(clk), .rst_n(rst_n), .on_req(on_req), .off_req(off_req),
    .pwr_ack_a(ack2_a), .pwr_ack_b(ack2_b), .mem_pd_ack(mem2_ack), .bp_ack(bp2_ack),
    .pwr_ctl(ctl2), .mem_pd(mem2_pd), .bp_req(bp2_req), .supply_en(sup2),
    .busy(busy2), .done(done2), .err(err2)
  );

  // Island model: acknowledges follow the controls one cycle later, 1 ns after the edge.
  always @(posedge clk) begin
    #1;
    ack_a    <= hold_a  ? hv_a  : ctl[2];
    ack_b    <= hold_b  ? hv_b  : ctl[3];
    bp_ack   <= hold_bp ? hv_bp : bp_req;
    mem_ack  <= mem_pd;
    ack2_a   <= ctl2[2];
    ack2_b   <= ctl2[3];
    mem2_ack <= mem2_pd;
  end

  logic [4:0]       t_ctl  [NTR];
  logic [MEM_W-1:0] t_mem  [NTR];
  logic             t_bp   [NTR];
  logic             t_done [NTR];
  logic             t_busy [NTR];
  logic             t_err  [NTR];
  logic             t_sup  [NTR];
  logic [4:0]       t2_ctl [NTR];
  logic             t2_done[NTR];
  logic             t2_bp  [NTR];
  int               t_n = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; on_req = 1'b0; off_req = 1'b0;
    hold_a = 1'b0; hold_b = 1'b0; hold_bp = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Pulse a request, then sample n cycles; sample 0 follows the accepting edge.
  // A stray off_req is raised at sample index inj (if inj >= 0).
  task automatic run_req(input bit on, input bit off, input int n, input int inj);
    @(negedge clk);
    on_req = on; off_req = off;
    @(negedge clk);
    on_req = 1'b0; off_req = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (k > 0) @(negedge clk);
      t_ctl[k] = ctl;   t_mem[k] = mem_pd; t_bp[k] = bp_req;
      t_done[k] = done; t_busy[k] = busy;  t_err[k] = err; t_sup[k] = sup;
      t2_ctl[k] = ctl2; t2_done[k] = done2; t2_bp[k] = bp2_req;
      off_req = (k == inj);
    end
    off_req = 1'b0;
    t_n = n;
  endtask

  function automatic int first_ctl(input logic [4:0] v);
    for (int k = 0; k < t_n; k++) if (t_ctl[k] == v) return k;
    return -1;
  endfunction

  function automatic int first_ctl2(input logic [4:0] v);
    for (int k = 0; k < t_n; k++) if (t2_ctl[k] == v) return k;
    return -1;
  endfunction

  function automatic int first_mem(input logic [MEM_W-1:0] v);
    for (int k = 0; k < t_n; k++) if (t_mem[k] == v) return k;
    return -1;
  endfunction

  function automatic int first_bp(input logic v);
    for (int k = 0; k < t_n; k++) if (t_bp[k] == v) return k;
    return -1;
  endfunction

  function automatic int first_done();
    for (int k = 0; k < t_n; k++) if (t_done[k]) return k;
    return -1;
  endfunction

  function automatic int first_done2();
    for (int k = 0; k < t_n; k++) if (t2_done[k]) return k;
    return -1;
  endfunction

  function automatic int first_err();
    for (int k = 0; k < t_n; k++) if (t_err[k]) return k;
    return -1;
  endfunction

  function automatic int count_bp2();
    int c = 0;
    for (int k = 0; k < t_n; k++) if (t2_bp[k]) c++;
    return c;
  endfunction

  task automatic t_reset_state();
    do_reset();
    chk("R1 ctl after reset", int'(ctl), 5'b10010);
    chk("R1 mem_pd after reset", int'(mem_pd), 4'hF);
    chk("R1 bp_req after reset", int'(bp_req), 1);
    chk("R1 bp_req after reset, no protection", int'(bp2_req), 0);
    chk("R1 supply/busy/done/err after reset", int'({sup, busy, done, err}), 0);
  endtask

  task automatic t_power_up();
    do_reset();
    run_req(1'b1, 1'b0, 30, 3);
    chk("R2 supply_en at accept", int'(t_sup[0]), 1);
    chk("R11 busy at accept", int'(t_busy[0]), 1);
    chk("R2 primary switch step", first_ctl(5'b10110), 1);
    chk("R2 secondary switch step", first_ctl(5'b11110), 2);
    chk("R4 clock ungate step", first_ctl(5'b01110), 4);
    chk("R4 isolation release step", first_ctl(5'b01100), 5);
    chk("R4 reset release step", first_ctl(5'b01101), 6);
    chk("R5 sram power-up step", first_mem(4'h0), 7);
    chk("R5 bus protection release step", first_bp(1'b0), 9);
    chk("R5 done pulse", first_done(), 10);
    chk("R11 busy low with done", int'(t_busy[10]), 0);
    chk("R11 stray off ignored", int'(t_ctl[29]), 5'b01101);
    chk("R10 no-protection copy done", first_done2(), 8);
    chk("R10 no-protection bp_req stays 0", count_bp2(), 0);
  endtask

  task automatic t_power_down();
    run_req(1'b0, 1'b1, 30, -1);
    chk("R6 bus protection raised", first_bp(1'b1), 1);
    chk("R6 sram power-down", first_mem(4'hF), 3);
    chk("R6 isolation set", first_ctl(5'b01111), 5);
    chk("R6 reset asserted", first_ctl(5'b01110), 6);
    chk("R6 clock gated", first_ctl(5'b11110), 7);
    chk("R6 primary opened", first_ctl(5'b11010), 8);
    chk("R6 secondary opened", first_ctl(5'b10010), 9);
    chk("R7 done when both acks low", first_done(), 10);
    chk("R7 supply before done", int'(t_sup[9]), 1);
    chk("R7 supply drops with done", int'(t_sup[10]), 0);
    chk("R10 no-protection isolation set", first_ctl2(5'b01111), 3);
    chk("R10 no-protection down done", first_done2(), 8);
  endtask

  task automatic t_both_requests();
    do_reset();
    run_req(1'b1, 1'b1, 4, -1);
    chk("R12 power-up wins", int'(t_ctl[1]), 5'b10110);
    chk("R12 bus protection untouched", int'(t_bp[1]), 1);
  endtask

  task automatic t_ack_mismatch();
    do_reset();
    hold_a = 1'b1; hv_a = 1'b0;
    run_req(1'b1, 1'b0, 12, -1);
    chk("R3 one ack only keeps waiting", int'(t_ctl[11]), 5'b11110);
    chk("R3 no ungate with mismatch", first_ctl(5'b01110), -1);
    hold_a = 1'b0;
    repeat (12) @(negedge clk);
    chk("R3 proceeds once both acks high", int'(ctl), 5'b01101);
  endtask

  task automatic t_ack_timeout();
    do_reset();
    hold_b = 1'b1; hv_b = 1'b0;
    run_req(1'b1, 1'b0, 24, -1);
    chk("R8 no error before limit", int'(t_err[17]), 0);
    chk("R3 still waiting before limit", int'(t_ctl[17]), 5'b11110);
    chk("R8 error at limit", int'(t_err[18]), 1);
    chk("R8 error one cycle", int'(t_err[19]), 0);
    chk("R11 busy low with error", int'(t_busy[18]), 0);
    chk("R8 no done on failure", first_done(), -1);
    chk("R9 ctl torn down", int'(t_ctl[18]), 5'b10010);
  endtask

  task automatic t_bp_timeout();
    do_reset();
    hold_bp = 1'b1; hv_bp = 1'b1;
    run_req(1'b1, 1'b0, 30, -1);
    chk("R9 island on before limit", int'(t_ctl[24]), 5'b01101);
    chk("R9 sram up before limit", int'(t_mem[24]), 0);
    chk("R8 error at bus-protection limit", first_err(), 25);
    chk("R9 ctl torn down", int'(t_ctl[25]), 5'b10010);
    chk("R9 sram down", int'(t_mem[25]), 4'hF);
    chk("R9 bus protection back", int'(t_bp[25]), 1);
    chk("R9 supply off", int'(t_sup[25]), 0);
  endtask

  task automatic t_down_timeout();
    do_reset();
    run_req(1'b1, 1'b0, 14, -1);
    hold_a = 1'b1; hv_a = 1'b1;
    run_req(1'b0, 1'b1, 30, -1);
    chk("R8 power-down error at limit", first_err(), 25);
    chk("R7 no done with ack still high", first_done(), -1);
    chk("R9 power-down failure keeps ctl", int'(t_ctl[25]), 5'b10010);
    chk("R9 power-down failure keeps supply", int'(t_sup[25]), 1);
  endtask

  initial begin
    t_reset_state();
    t_power_up();
    t_power_down();
    t_both_requests();
    t_ack_mismatch();
    t_ack_timeout();
    t_bp_timeout();
    t_down_timeout();
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
    summary();
    $finish;
  end

endmodule